// File: doc/BRIEF.md
# Read-Priority Bank Scheduler for Slow-Write Memory

This block schedules one bank of a memory whose writes take far longer than its reads. Read and write requests come from the host side on separate request ports. Writes are absorbed into a write buffer at once, so the host is never held up while a write is programmed. Reads wait in their own queue. The bank programs a write as a string of program iterations. Each request states its own iteration count, and every iteration lasts a fixed number of cycles. A read holds the bank for a shorter fixed latency.

Reads come first. A write is only started while no read is waiting. Once a write is under way, a read that arrives still has two ways to get ahead of it:
- **Cancellation.** A freshly started write can be abandoned while it is still within a programmable window. It stays at the head of the buffer and later starts over from its first iteration.
- **Pausing.** Any write can be suspended between two iterations. It later carries on from the next iteration.

When the write buffer is full, both escapes are switched off, so the buffer is sure to drain.

A read returns its address as a tag. Its data comes from the youngest write to that address that was accepted before the read went to the bank, whether that write is still buffered or already stored.

Top module: `pcm_bank_sched`

## Requirements
- R1: When the bank is idle and a read is waiting, the next bank operation is that read, even if writes are buffered. A buffered write starts only from an idle bank with an empty read queue.
- R2: `rd_ready` is high exactly when the read queue holds fewer than RQ_DEPTH entries. `wr_ready` is high exactly when the write buffer holds fewer than WQ_DEPTH entries. A request is taken on a cycle where its valid and ready are both high.
- R3: A read issued at a clock edge keeps `bank_op` at 1 for RD_LAT cycles. `rsp_valid` then pulses for the single following cycle.
- R4: `wr_iters` holds the iteration count minus one, so the values 0 to 7 mean 1 to 8 iterations. Each iteration shows `bank_op` at 2 for ITER_LAT cycles. A write that is never interrupted programs for iterations×ITER_LAT cycles, after which the bank is idle for one cycle.
- R5: Suppose a write was started from its first iteration, a read is waiting, and the write has spent fewer than `cancel_win` cycles programming, counting 0 in its first program cycle. Then the write is cancelled and `bank_op` is 0 on the next cycle. A `cancel_win` of 0 disables cancellation.
- R6: A cancelled write stays at the head of the write buffer. It restarts later from iteration one, with a new cancellation window.
- R7: At the end of an iteration that is not the write's last, a waiting read suspends the write. The write resumes afterwards at its next iteration. A resumed write cannot be cancelled.
- R8: Once the cancellation window has run out, a waiting read no longer stops the write mid-iteration. The read waits for the next iteration boundary.
- R9: While the write buffer is full, a write in progress is neither cancelled nor paused.
- R10: Responses appear in the order the reads were accepted. `rsp_addr` carries the read's address.
- R11: `rsp_data` is the data of the youngest write to that address accepted before the read was issued, whether it is still buffered or already stored. It is zero if no such write exists since reset.
- R12: After reset, both queues are empty, `bank_op` is 0, `rsp_valid` is 0 and every stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | 4 | Read address |
| rd_ready | output | 1 | Read queue has room |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| wr_iters | input | 3 | Program iterations minus one |
| wr_ready | output | 1 | Write buffer has room |
| cancel_win | input | WIN_W | Cancellation window in cycles, 0 disables cancellation |
| rsp_valid | output | 1 | Read response strobe |
| rsp_addr | output | 4 | Address tag of the response |
| rsp_data | output | 16 | Read data |
| bank_op | output | 2 | Bank operation this cycle: 0 idle, 1 read, 2 program |

## Verification
A read accepted at edge k into an idle, empty controller is issued at edge k+1. It shows `bank_op`=1 from then on for RD_LAT cycles, and its response is visible during the cycle after edge k+1+RD_LAT. A cancellation or a pause shows up as `bank_op` falling to 0 one cycle after the deciding condition. The read follows on the next edge, and iteration boundaries fall every ITER_LAT cycles from a write's start. A behavioural model advanced at each rising edge predicts all of these cycle positions. The bench compares every output against that model at the falling edge, so each result is sampled in the cycle it is due and never straddles a register update.

// File: rtl/pcm_sched_pkg.sv
package pcm_sched_pkg;

    localparam int PCM_ADDR_W = 4;
    localparam int PCM_DATA_W = 16;
    localparam int PCM_ITER_W = 3;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_PROG = 2'd2
    } bank_op_e;

    typedef logic [PCM_ADDR_W-1:0] pcm_addr_t;
    typedef logic [PCM_DATA_W-1:0] pcm_data_t;
    typedef logic [PCM_ITER_W:0]   pcm_iter_t;

    typedef struct packed {
        pcm_addr_t               addr;
        pcm_data_t               data;
        logic [PCM_ITER_W-1:0]   iters_m1;
    } wr_entry_t;

    // Number of program iterations a request asks for (field holds count - 1).
    function automatic pcm_iter_t iter_total(input logic [PCM_ITER_W-1:0] f);
        return {1'b0, f} + {{PCM_ITER_W{1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/pcm_rd_queue.sv
module pcm_rd_queue
    import pcm_sched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  pcm_addr_t din,
    input  logic      pop,
    output pcm_addr_t dout,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    pcm_addr_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_ONE;
            if (pop)  rd_ptr <= rd_ptr + PTR_ONE;
            case ({push, pop})
                2'b10:   count <= count + CNT_ONE;
                2'b01:   count <= count - CNT_ONE;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    p_rq_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        push |-> (count != FULL_CNT));

    p_rq_pop_valid_r10: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

endmodule

// File: rtl/pcm_wr_buffer.sv
module pcm_wr_buffer
    import pcm_sched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wr_entry_t din,
    input  logic      pop,
    output wr_entry_t head,
    output logic      empty,
    output logic      full,
    input  pcm_addr_t look_addr,
    output logic      look_hit,
    output pcm_data_t look_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    wr_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_ONE;
            if (pop)  rd_ptr <= rd_ptr + PTR_ONE;
            case ({push, pop})
                2'b10:   count <= count + CNT_ONE;
                2'b01:   count <= count - CNT_ONE;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    // Per-slot match, walked oldest to youngest so the youngest match wins.
    logic [DEPTH-1:0] slot_hit;
    pcm_data_t        slot_data [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PTR_W-1:0] idx;
        assign idx          = rd_ptr + PTR_W'(g);
        assign slot_hit[g]  = (CNT_W'(g) < count) && (mem[idx].addr == look_addr);
        assign slot_data[g] = mem[idx].data;
    end

    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_hit[i]) begin
                look_hit  = 1'b1;
                look_data = slot_data[i];
            end
        end
    end

    p_wq_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        push |-> (count != FULL_CNT));

    p_wq_pop_valid_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

endmodule

// File: rtl/pcm_bank_array.sv
module pcm_bank_array
    import pcm_sched_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  pcm_addr_t waddr,
    input  pcm_data_t wdata,
    input  pcm_addr_t raddr,
    output pcm_data_t rdata
);
    localparam int WORDS = 1 << PCM_ADDR_W;

    pcm_data_t cells [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/pcm_bank_sched.sv
module pcm_bank_sched
    import pcm_sched_pkg::*;
#(
    parameter int RQ_DEPTH = 4,
    parameter int WQ_DEPTH = 4,
    parameter int RD_LAT   = 3,
    parameter int ITER_LAT = 8,
    parameter int WIN_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_valid,
    input  logic [PCM_ADDR_W-1:0] rd_addr,
    output logic                  rd_ready,
    input  logic                  wr_valid,
    input  logic [PCM_ADDR_W-1:0] wr_addr,
    input  logic [PCM_DATA_W-1:0] wr_data,
    input  logic [PCM_ITER_W-1:0] wr_iters,
    output logic                  wr_ready,
    input  logic [WIN_W-1:0]      cancel_win,
    output logic                  rsp_valid,
    output logic [PCM_ADDR_W-1:0] rsp_addr,
    output logic [PCM_DATA_W-1:0] rsp_data,
    output logic [1:0]            bank_op
);
    localparam int LAT_MAX = (ITER_LAT > RD_LAT) ? ITER_LAT : RD_LAT;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam logic [CNT_W-1:0] RD_INIT  = CNT_W'(RD_LAT - 1);
    localparam logic [CNT_W-1:0] IT_INIT  = CNT_W'(ITER_LAT - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [WIN_W-1:0] WIN_ONE  = WIN_W'(1);
    localparam logic [WIN_W-1:0] WIN_SAT  = {WIN_W{1'b1}};
    localparam pcm_iter_t        ITER_ONE = pcm_iter_t'(1);

    // ---------------- queues and storage ----------------
    logic      rq_push, rq_pop, rq_empty, rq_full;
    pcm_addr_t rq_head;
    logic      wq_push, wq_pop, wq_empty, wq_full;
    wr_entry_t wq_in, wq_head;
    logic      fwd_hit;
    pcm_data_t fwd_data, arr_data;

    assign rd_ready = !rq_full;
    assign wr_ready = !wq_full;
    assign rq_push  = rd_valid && !rq_full;
    assign wq_push  = wr_valid && !wq_full;
    assign wq_in    = '{addr: wr_addr, data: wr_data, iters_m1: wr_iters};

    pcm_rd_queue #(.DEPTH(RQ_DEPTH)) u_rq (
        .clk(clk), .rst(rst), .push(rq_push), .din(rd_addr), .pop(rq_pop),
        .dout(rq_head), .empty(rq_empty), .full(rq_full)
    );

    pcm_wr_buffer #(.DEPTH(WQ_DEPTH)) u_wq (
        .clk(clk), .rst(rst), .push(wq_push), .din(wq_in), .pop(wq_pop),
        .head(wq_head), .empty(wq_empty), .full(wq_full),
        .look_addr(rq_head), .look_hit(fwd_hit), .look_data(fwd_data)
    );

    pcm_bank_array u_arr (
        .clk(clk), .rst(rst), .we(wq_pop), .waddr(wq_head.addr), .wdata(wq_head.data),
        .raddr(rq_head), .rdata(arr_data)
    );

    // ---------------- scheduler state ----------------
    bank_op_e         state;
    logic [CNT_W-1:0] cnt;
    pcm_iter_t        prog;      // iterations of the head write already finished
    logic [WIN_W-1:0] elapsed;   // program cycles since a fresh start
    logic             fresh;     // current write began at iteration one
    pcm_addr_t        rd_addr_q;
    pcm_data_t        rd_data_q;

    logic      cancel_now, iter_end, wr_finish, pause_now;
    pcm_iter_t prog_next;

    assign rq_pop     = (state == OP_IDLE) && !rq_empty;
    assign cancel_now = (state == OP_PROG) && fresh && !rq_empty
                        && (elapsed < cancel_win) && !wq_full;
    assign iter_end   = (state == OP_PROG) && !cancel_now && (cnt == '0);
    assign prog_next  = prog + ITER_ONE;
    assign wr_finish  = iter_end && (prog_next == iter_total(wq_head.iters_m1));
    assign pause_now  = iter_end && !wr_finish && !rq_empty && !wq_full;
    assign wq_pop     = wr_finish;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= OP_IDLE;
            cnt       <= '0;
            prog      <= '0;
            elapsed   <= '0;
            fresh     <= 1'b0;
            rd_addr_q <= '0;
            rd_data_q <= '0;
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                OP_IDLE: begin
                    if (!rq_empty) begin
                        rd_addr_q <= rq_head;
                        rd_data_q <= fwd_hit ? fwd_data : arr_data;
                        cnt       <= RD_INIT;
                        state     <= OP_READ;
                    end else if (!wq_empty) begin
                        cnt     <= IT_INIT;
                        elapsed <= '0;
                        fresh   <= (prog == '0);
                        state   <= OP_PROG;
                    end
                end
                OP_READ: begin
                    if (cnt == '0) begin
                        rsp_valid <= 1'b1;
                        rsp_addr  <= rd_addr_q;
                        rsp_data  <= rd_data_q;
                        state     <= OP_IDLE;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                OP_PROG: begin
                    if (elapsed != WIN_SAT) elapsed <= elapsed + WIN_ONE;
                    if (cancel_now) begin
                        prog  <= '0;
                        state <= OP_IDLE;
                    end else if (iter_end) begin
                        if (wr_finish) begin
                            prog  <= '0;
                            state <= OP_IDLE;
                        end else if (pause_now) begin
                            prog  <= prog_next;
                            state <= OP_IDLE;
                        end else begin
                            prog <= prog_next;
                            cnt  <= IT_INIT;
                        end
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                default: state <= OP_IDLE;
            endcase
        end
    end

    assign bank_op = state;

    // ---------------- assertions ----------------
    p_read_first_r1: assert property (@(posedge clk) disable iff (rst)
        (state == OP_IDLE && !rq_empty) |=> (state == OP_READ));

    p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(state) == OP_READ));

    p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
        (state == OP_PROG && fresh && !rq_empty && elapsed < cancel_win && !wq_full)
        |=> (state == OP_IDLE && prog == '0));

    p_resume_keeps_progress_r7: assert property (@(posedge clk) disable iff (rst)
        (state == OP_IDLE && rq_empty && !wq_empty && prog != '0)
        |=> (state == OP_PROG && $stable(prog) && !fresh));

    p_full_no_yield_r9: assert property (@(posedge clk) disable iff (rst)
        (state == OP_PROG && wq_full && !wq_pop) |=> (state == OP_PROG));

endmodule

// File: tb/pcm_bank_sched_tb.sv
`timescale 1ns/1ps
module pcm_bank_sched_tb;
    localparam int RQ_D = 4;
    localparam int WQ_D = 4;
    localparam int RD_LAT = 3;
    localparam int IT_LAT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_valid = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_ready;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  wr_iters = '0;
    logic        wr_ready;
    logic [7:0]  cancel_win = 8'd20;
    logic        rsp_valid;
    logic [3:0]  rsp_addr;
    logic [15:0] rsp_data;
    logic [1:0]  bank_op;

    always #4 clk = ~clk;   // 125 MHz

    pcm_bank_sched #(.RQ_DEPTH(RQ_D), .WQ_DEPTH(WQ_D), .RD_LAT(RD_LAT),
                     .ITER_LAT(IT_LAT), .WIN_W(8)) u_dut (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_iters(wr_iters), .wr_ready(wr_ready), .cancel_win(cancel_win),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .bank_op(bank_op)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R12";
    bit    done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s) %s actual=%0d expected=%0d", req, tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_state, m_cnt, m_prog, m_elapsed;
    bit          m_fresh;
    int          rq[$];
    int          wq[$];
    logic [15:0] shadow [16];
    bit          m_rsp_valid;
    int          m_rsp_addr, m_rd_addr;
    logic [15:0] m_rsp_data, m_rd_data;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_cnt = 0; m_prog = 0; m_elapsed = 0; m_fresh = 0;
            rq.delete(); wq.delete();
            for (int i = 0; i < 16; i++) shadow[i] = '0;
            m_rsp_valid = 0; m_rsp_addr = 0; m_rsp_data = '0;
        end else begin
            int  nrd, nwq;
            bit  acc_rd, acc_wr, full;
            nrd = rq.size();
            nwq = wq.size();
            acc_rd = rd_valid && (nrd < RQ_D);
            acc_wr = wr_valid && (nwq < WQ_D);
            full   = (nwq == WQ_D);
            m_rsp_valid = 0;
            case (m_state)
                0: begin
                    if (nrd > 0) begin
                        m_rd_addr = rq.pop_front();
                        m_rd_data = shadow[m_rd_addr];
                        m_cnt = RD_LAT - 1;
                        m_state = 1;
                    end else if (nwq > 0) begin
                        m_fresh = (m_prog == 0);
                        m_elapsed = 0;
                        m_cnt = IT_LAT - 1;
                        m_state = 2;
                    end
                end
                1: begin
                    if (m_cnt == 0) begin
                        m_rsp_valid = 1;
                        m_rsp_addr = m_rd_addr;
                        m_rsp_data = m_rd_data;
                        m_state = 0;
                    end else m_cnt--;
                end
                default: begin
                    if (m_fresh && nrd > 0 && m_elapsed < int'(cancel_win) && !full) begin
                        m_state = 0;
                        m_prog = 0;
                    end else if (m_cnt == 0) begin
                        m_prog++;
                        if (m_prog == wq[0]) begin
                            void'(wq.pop_front());
                            m_prog = 0;
                            m_state = 0;
                        end else if (nrd > 0 && !full) begin
                            m_state = 0;
                        end else m_cnt = IT_LAT - 1;
                    end else m_cnt--;
                    m_elapsed++;
                end
            endcase
            if (acc_rd) rq.push_back(int'(rd_addr));
            if (acc_wr) begin
                wq.push_back(int'(wr_iters) + 1);
                shadow[wr_addr] = wr_data;
            end
        end
    end

    // ---------------- compare every cycle, away from the active edge ----------------
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(rd_ready == (rq.size() < RQ_D), "R2", "rd_ready", rd_ready, rq.size() < RQ_D);
            check(wr_ready == (wq.size() < WQ_D), "R2", "wr_ready", wr_ready, wq.size() < WQ_D);
            check(int'(bank_op) == m_state, tag, "bank_op", bank_op, m_state);
            check(rsp_valid == m_rsp_valid, "R3", "rsp_valid", rsp_valid, m_rsp_valid);
            if (m_rsp_valid) begin
                check(int'(rsp_addr) == m_rsp_addr, "R10", "rsp_addr", rsp_addr, m_rsp_addr);
                check(rsp_data == m_rsp_data, "R11", "rsp_data", rsp_data, m_rsp_data);
            end
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rd(input int a);
        while (!rd_ready) @(negedge clk);
        rd_valid = 1'b1;
        rd_addr  = 4'(a);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic send_wr(input int a, input int d, input int it_m1);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = 4'(a);
        wr_data  = 16'(d);
        wr_iters = 3'(it_m1);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((m_state != 0 || rq.size() != 0 || wq.size() != 0 || m_rsp_valid) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: state straight after reset
        tag = "R12";
        check(rd_ready == 1'b1, "R12", "rd_ready after reset", rd_ready, 1);
        check(wr_ready == 1'b1, "R12", "wr_ready after reset", wr_ready, 1);
        check(bank_op == 2'd0, "R12", "bank_op after reset", bank_op, 0);
        check(rsp_valid == 1'b0, "R12", "rsp_valid after reset", rsp_valid, 0);

        // R12/R10/R2: unwritten addresses read back zero, reads overflow the queue
        for (int i = 0; i < 7; i++) send_rd(15 - i);
        drain();

        // R1: write and read arrive together, the read goes first
        tag = "R1";
        wr_valid = 1'b1; wr_addr = 4'd5; wr_data = 16'h1234; wr_iters = 3'd1;
        rd_valid = 1'b1; rd_addr = 4'd6;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        drain();

        // R4: uninterrupted write of three iterations, then read it back
        tag = "R4";
        send_wr(7, 16'hBEEF, 2);
        drain();
        send_rd(7);
        drain();

        // R11: read of an address whose write is still buffered
        tag = "R11";
        cancel_win = 8'd0;
        send_wr(9, 16'hA5A5, 7);
        send_wr(9, 16'h5A5A, 0);
        send_rd(9);
        drain();

        // R5 then R6: read inside the window cancels; write restarts from iteration one
        tag = "R5";
        cancel_win = 8'd20;
        send_wr(3, 16'h0333, 7);
        idle(5);
        send_rd(4);
        idle(6);
        tag = "R6";
        idle(4);
        send_rd(3);
        drain();

        // R8 then R7: window expired, read waits for the boundary, write resumes
        tag = "R8";
        cancel_win = 8'd4;
        send_wr(11, 16'h0B0B, 5);
        idle(12);
        send_rd(11);
        idle(4);
        tag = "R7";
        idle(10);
        send_rd(2);
        drain();

        // R9: full write buffer suppresses cancel and pause
        tag = "R9";
        cancel_win = 8'd40;
        for (int i = 0; i < 5; i++) send_wr(i, 16'h9000 + i, 1);
        send_rd(0);
        send_rd(1);
        drain();

        // R10: mixed traffic
        tag = "R10";
        for (int c = 0; c < 1500; c++) begin
            if (c % 150 == 0) cancel_win = 8'($urandom_range(0, 30));
            rd_valid = rd_ready && ($urandom_range(0, 3) == 0);
            rd_addr  = 4'($urandom_range(0, 15));
            wr_valid = wr_ready && ($urandom_range(0, 9) == 0);
            wr_addr  = 4'($urandom_range(0, 15));
            wr_data  = 16'($urandom);
            wr_iters = 3'($urandom_range(0, 7));
            @(negedge clk);
        end
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        drain();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog (phase %s) timeout actual=1 expected=0", tag);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule